// File: doc/BRIEF.md
# Seven-Level Interrupt Enable and Priority Encoder

This block sits between seven interrupt request lines and a processor that takes its interrupt priority as a 3-bit, active-low code. Each request line belongs to one priority level from 1 to 7. A request is first brought into the clock domain. The block then catches its rising edge and holds it as a pending interrupt, but only if software has enabled that level and has not masked everything. The highest pending level is driven onto the priority output.

Software uses two registers, chosen by a one-bit register select. The control register holds the global mask and the seven per-level enables. The status register shows the current priority code in its low three bits. Once a level has fired, it stays pending until software writes its enable bit to zero. Writing the bit back to one arms the level for its next rising edge.

Top module: `irq_level_front`

## Requirements
- R1: While reset is asserted and after it is released, the control register reads 0x00, the priority output reads 3'b111 and the status register reads 0x07.
- R2: A write with `regSel` = 0 loads `wrData` into the control register on that clock edge. A read with `regSel` = 0 returns the stored value unchanged.
- R3: Control bit n (n = 1..7) enables level n, and request input bit n-1 carries level n. When a request rises on an enabled level while control bit 0 is 0, the level becomes pending. It appears on `iplN` as the inverted level number (~n) on the third rising clock edge after the input changes, and not on the second.
- R4: While control bit 0 is 1, no rising request latches a new pending level, whatever the per-level enables hold.
- R5: A rising request on a level whose enable bit is 0 has no effect on `iplN`.
- R6: A write that clears an enable bit removes that level's pending state on the same clock edge, so `iplN` shows the next lower pending level or 3'b111. After the level is re-armed, a request held high does not fire again until it has gone low and risen once more.
- R7: When several levels are pending, `iplN` carries the highest-numbered one.
- R8: A read with `regSel` = 1 returns `iplN` in bits 2:0 and zeros in bits 7:3.
- R9: A pending level stays pending after its request input returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 1 | Register select: 0 = control, 1 = status |
| wrEn | input | 1 | Write strobe, acts on the control register only |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register |
| irqReq | input | 7 | Request lines; bit 0 is level 1, bit 6 is level 7 |
| iplN | output | 3 | Active-low priority code of the highest pending level |

## Verification
A register write takes effect on the clock edge that samples it. The bench therefore reads the control register back, and checks that a cleared level has left `iplN`, half a cycle after that edge. A request edge needs three rising clock edges to reach `iplN`: two synchronizer stages and then the pending latch. Each stimulus is applied at a falling edge, and the result is sampled at the falling edge after the third rising edge. For R3 the bench also samples one cycle earlier to confirm the output has not yet moved. The status register is a combinational view of the current code, so it is checked in the same half cycle as `iplN`.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int LEVELS = 7;
  localparam int LVL_W  = $clog2(LEVELS + 1);
  localparam int REG_W  = LEVELS + 1;

  typedef struct packed {
    logic enableLoad;   // load control register this edge
    logic statusSel;    // route status view to read data
  } strobes_t;
endpackage

// File: rtl/irqf_ctrl.sv
module irqf_ctrl
  import irqf_pkg::*;
(
  input  logic     regSel,
  input  logic     wrEn,
  output strobes_t strb
);
  always_comb begin
    strb.enableLoad = wrEn & ~regSel;
    strb.statusSel  = regSel;
  end
endmodule

// File: rtl/irqf_datapath.sv
module irqf_datapath
  import irqf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  logic [REG_W-1:0] wrData,
  input  logic [LEVELS-1:0] irqReq,
  output logic [LVL_W-1:0] iplN,
  output logic [REG_W-1:0] rdData,
  output logic [REG_W-1:0] enableQ
);
  logic [SYNC_STAGES-1:0][LEVELS-1:0] syncPipe;
  logic [LEVELS-1:0] lastSeen;
  logic [LEVELS-1:0] riseSeen;
  logic [LEVELS-1:0] armed;
  logic [LEVELS-1:0] pendQ;
  logic [LEVELS-1:0] pendNext;
  logic [REG_W-1:0]  enableNext;
  logic [LVL_W-1:0]  levelNum;

  // synchronizer chain, one stage per generate iteration
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncPipe[0] <= '0;
        else       syncPipe[0] <= irqReq;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncPipe[s] <= '0;
        else       syncPipe[s] <= syncPipe[s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) lastSeen <= '0;
    else       lastSeen <= syncPipe[SYNC_STAGES-1];

  always_comb begin
    riseSeen   = syncPipe[SYNC_STAGES-1] & ~lastSeen;
    enableNext = strb.enableLoad ? wrData : enableQ;
    armed      = enableQ[REG_W-1:1] & {LEVELS{~enableQ[0]}};
    pendNext   = (pendQ | (riseSeen & armed)) & enableNext[REG_W-1:1];
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      enableQ <= '0;
      pendQ   <= '0;
    end else begin
      enableQ <= enableNext;
      pendQ   <= pendNext;
    end

  // highest-numbered pending level wins
  always_comb begin
    levelNum = '0;
    for (int i = 0; i < LEVELS; i++)
      if (pendQ[i]) levelNum = LVL_W'(i + 1);
  end

  assign iplN   = ~levelNum;
  assign rdData = strb.statusSel ? {{(REG_W-LVL_W){1'b0}}, iplN} : enableQ;
endmodule

// File: rtl/irq_level_front.sv
module irq_level_front
  import irqf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regSel,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic [6:0] irqReq,
  output logic [2:0] iplN
);
  strobes_t         strb;
  logic [REG_W-1:0] enableQ;

  irqf_ctrl u_ctrl (
    .regSel (regSel),
    .wrEn   (wrEn),
    .strb   (strb)
  );

  irqf_datapath #(.SYNC_STAGES(2)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .irqReq  (irqReq),
    .iplN    (iplN),
    .rdData  (rdData),
    .enableQ (enableQ)
  );
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker (
  input logic       clk,
  input logic       rstN,
  input logic       regSel,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic [7:0] enableQ,
  input logic [2:0] iplN
);
  always @(posedge clk)
    if (!rstN) AST_RESET_IDLE: assert (iplN == 3'b111 && enableQ == 8'h00); // R1

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !regSel) |=> enableQ == $past(wrData)); // R2

  AST_MASK_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $past(enableQ[0]) |-> iplN >= $past(iplN)); // R4

  AST_ALL_OFF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ[7:1] == 7'h00) |-> iplN == 3'b111); // R6

  AST_STATUS_VIEW: assert property (@(posedge clk) disable iff (!rstN)
    regSel |-> (rdData[2:0] == iplN && rdData[7:3] == 5'b0)); // R8
endmodule

bind irq_level_front irqf_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regSel  (regSel),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .rdData  (rdData),
  .enableQ (enableQ),
  .iplN    (iplN)
);

// File: tb/tb_irq_level_front.sv
module tb_irq_level_front;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {control value, request pattern, expected iplN}
  localparam logic [17:0] VECS [NVEC] = '{
    {8'hFE, 7'h01, 3'd6},  // R3 level 1
    {8'hFE, 7'h40, 3'd0},  // R3 level 7
    {8'hFE, 7'h15, 3'd2},  // R7 levels 1,3,5 -> 5
    {8'hFF, 7'h7F, 3'd7},  // R4 masked
    {8'h04, 7'h7F, 3'd5},  // R5 only level 2 enabled
    {8'h00, 7'h7F, 3'd7},  // R5 nothing enabled
    {8'h80, 7'h40, 3'd0},  // R3 level 7 alone
    {8'h12, 7'h0F, 3'd3}   // R7 levels 1,4 enabled -> 4
  };

  logic clk = 0, rstN = 0, regSel = 0, wrEn = 0;
  logic [7:0] wrData = 0, rdData;
  logic [6:0] irqReq = 0;
  logic [2:0] iplN;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_level_front dut (.*);

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic regWrite(logic [7:0] v);
    regSel = 0; wrData = v; wrEn = 1;
    tick(1);
    wrEn = 0;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearAll();
    regWrite(8'h00);
    irqReq = 0;
    tick(3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1 during reset
    check("R1", {5'b0, iplN}, 8'h07);
    tick(2);
    rstN = 1;
    tick(1);
    check("R1", rdData, 8'h00);
    regSel = 1; #1;
    check("R1", rdData, 8'h07);
    regSel = 0;

    // R2 write/read
    regWrite(8'hA5);
    check("R2", rdData, 8'hA5);

    // table walk
    for (int k = 0; k < NVEC; k++) begin
      clearAll();
      regWrite(VECS[k][17:10]);
      irqReq = VECS[k][9:3];
      tick(3);
      check("R3/R4/R5/R7 ipl", {5'b0, iplN}, {5'b0, VECS[k][2:0]});
      regSel = 1; #1;
      check("R8 status", rdData, {5'b0, VECS[k][2:0]});
      regSel = 0;
    end

    // R3 latency: not on 2nd edge, present on 3rd
    clearAll();
    regWrite(8'h08);
    irqReq = 7'h04;
    tick(2);
    check("R3 early", {5'b0, iplN}, 8'h07);
    tick(1);
    check("R3 due", {5'b0, iplN}, 8'h04);

    // R9 holds after input drops
    irqReq = 0;
    tick(4);
    check("R9", {5'b0, iplN}, 8'h04);

    // R6 same-edge clear
    regWrite(8'h00);
    check("R6 clear", {5'b0, iplN}, 8'h07);
    // R5 rising edge while disabled ignored
    irqReq = 7'h04;
    tick(3);
    check("R5", {5'b0, iplN}, 8'h07);
    // R6 re-arm with input held high: no fire
    regWrite(8'h08);
    tick(4);
    check("R6 held", {5'b0, iplN}, 8'h07);
    irqReq = 0; tick(3);
    irqReq = 7'h04; tick(3);
    check("R6 refire", {5'b0, iplN}, 8'h04);

    // R6 partial clear drops to next pending level (3 and 5 pending)
    clearAll();
    regWrite(8'h28);
    irqReq = 7'h14;
    tick(3);
    check("R7 pair", {5'b0, iplN}, 8'h02);
    regWrite(8'h08);
    check("R6 next", {5'b0, iplN}, 8'h04);

    // R4 mask set after arming blocks new edges
    clearAll();
    regWrite(8'h81);
    irqReq = 7'h40;
    tick(3);
    check("R4 mask", {5'b0, iplN}, 8'h07);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule